// File: doc/BRIEF.md
# Matrix Keyboard Scanner with Key Queue

This block drives a row index onto an external key matrix, reads back the column return lines of the selected row, and turns what it sees into entries in an eight-deep queue that a host drains one word at a time. Each matrix position is filtered over whole scans, so contact bounce never produces an entry.

Three operating modes are chosen through a configuration write. In the two key modes, only newly settled presses produce entries. The exclusive mode admits a press only while it is the sole key held. The independent mode admits every settled press on its own. The raw mode skips filtering and records, row by row, each change in the return-line pattern. The host sets the row dwell time with the same write. The interrupt line stays high while the queue holds unread words. A sticky flag marks a dropped entry.

Top module: `kbscan_ctrl`

## Requirements
- R1: After reset, `irq` and `ovr` are 0, `scan_row` is 0, the queue is empty, the mode is exclusive and the dwell value is 3.
- R2: A write with `cfg_we` loads the mode from `cfg_wdata[9:8]` (0 = exclusive, 1 = independent, 2 = raw, 3 = exclusive) and the dwell value P from `cfg_wdata[7:0]`. It returns `scan_row` to 0 and clears all per-key state. Afterwards `scan_row` holds each row for P+1 cycles and wraps from 7 to 0.
- R3: In the key modes, a press is entered only after it reads pressed on two consecutive visits of its row. A press shorter than one full scan is never entered, and no entry appears within one scan of the press.
- R4: A key entry reads `rd_data[10:8]` = row, `rd_data[2:0]` = column and `rd_data[7:3]` = 0.
- R5: In independent mode, every settled press is entered regardless of other held keys. When several keys in one row settle on the same visit, the lowest column is entered on that visit and each of the others on a later visit, one per visit.
- R6: In exclusive mode, a settled press is entered only when it is the only settled key down. A press held back this way is entered once every other key has settled released.
- R7: A held key is entered once. It can be entered again only after a settled release and a new press. Releases produce no entry.
- R8: In raw mode, each visit of a row whose return pattern differs from the pattern seen on its previous visit pushes `rd_data[10:8]` = row and `rd_data[7:0]` = the raw pattern. There is no filtering.
- R9: The queue holds 8 words and returns them in order. `rd_data` shows the oldest word, and `rd_stb` removes it. `rd_stb` while the queue is empty has no effect.
- R10: `irq` is 1 exactly while the queue holds at least one word.
- R11: An entry that arrives while the queue is full is dropped and sets `ovr`. `ovr` stays set until the next `rd_stb`, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 10 | Mode in [9:8], dwell value in [7:0] |
| scan_row | output | 3 | Row currently selected in the matrix |
| ret_in | input | 8 | Return lines of the selected row, 1 = closed |
| rd_stb | input | 1 | Removes the oldest queue word |
| rd_data | output | 11 | Oldest queue word |
| irq | output | 1 | Queue not empty |
| ovr | output | 1 | Sticky dropped-entry flag |

## Verification
The scan row changes on the edge that ends each P+1 cycle dwell. Every entry appears in `rd_data` and `irq` on the edge of the visit that produces it. This puts a key entry between one and two full scans after the press, and a raw-mode entry within one scan. The bench uses P = 1, so one scan is 16 cycles, and it samples at falling edges. For an absence it checks at exactly one scan after the stimulus. For a presence it waits at least three scans, and four or more where a second settle or a later row visit is involved. Dwell periods are counted edge to edge between row changes.

// File: rtl/kbscan_pkg.sv
package kbscan_pkg;

    localparam int KB_ROWS  = 8;
    localparam int KB_COLS  = 8;
    localparam int KB_PRE_W = 8;

    typedef enum logic [1:0] {
        MODE_EXCL = 2'd0,
        MODE_INDEP = 2'd1,
        MODE_RAW = 2'd2
    } kb_mode_e;

    function automatic kb_mode_e kb_mode_decode(input logic [1:0] code);
        case (code)
            2'd1:    return MODE_INDEP;
            2'd2:    return MODE_RAW;
            default: return MODE_EXCL;
        endcase
    endfunction

endpackage

// File: rtl/kb_timer.sv
module kb_timer #(
    parameter int ROWS  = 8,
    parameter int PRE_W = 8,
    localparam int ROW_W = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic [PRE_W-1:0] presc,
    output logic [ROW_W-1:0] row,
    output logic             tick
);

    logic [PRE_W-1:0] cnt_q;

    assign tick = (cnt_q == presc);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q <= '0;
            row   <= '0;
        end else if (tick) begin
            cnt_q <= '0;
            row   <= (row == ROW_W'(ROWS - 1)) ? '0 : row + ROW_W'(1);
        end else begin
            cnt_q <= cnt_q + PRE_W'(1);
        end
    end

endmodule

// File: rtl/kb_matrix.sv
module kb_matrix
    import kbscan_pkg::*;
#(
    parameter int ROWS = 8,
    parameter int COLS = 8,
    localparam int ROW_W = $clog2(ROWS),
    localparam int COL_W = $clog2(COLS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             tick,
    input  logic [ROW_W-1:0] row,
    input  logic [COLS-1:0]  ret,
    input  kb_mode_e         mode,
    output logic             push_vld,
    output logic [ROW_W-1:0] push_row,
    output logic [COLS-1:0]  push_data
);

    // per-key state: last raw sample, settled level, already-entered
    logic [ROWS-1:0][COLS-1:0] prev_q, deb_q, ent_q;

    logic [COLS-1:0]  cur_prev, cur_deb, new_deb, keep_ent, cand, new_ent;
    logic [COL_W-1:0] pick;
    logic             key_push, raw_push, allow;
    int               total;

    assign cur_prev = prev_q[row];
    assign cur_deb  = deb_q[row];

    // settle high when two samples agree high, low when two agree low
    assign new_deb  = (ret & cur_prev) | (cur_deb & (ret | cur_prev));
    assign keep_ent = ent_q[row] & new_deb;
    assign cand     = new_deb & ~keep_ent;

    always_comb begin
        total = 0;
        for (int r = 0; r < ROWS; r++) begin
            if (ROW_W'(r) == row)
                total += $countones(new_deb);
            else
                total += $countones(deb_q[r]);
        end
    end

    always_comb begin
        pick = '0;
        for (int c = COLS - 1; c >= 0; c--) begin
            if (cand[c]) pick = COL_W'(c);
        end
    end

    assign allow    = (mode == MODE_INDEP) || (total == 1);
    assign key_push = tick && (mode != MODE_RAW) && (|cand) && allow;
    assign raw_push = tick && (mode == MODE_RAW) && (ret != cur_prev);
    assign new_ent  = keep_ent | (key_push ? (COLS'(1) << pick) : '0);

    assign push_vld  = key_push || raw_push;
    assign push_row  = row;
    assign push_data = (mode == MODE_RAW) ? ret : COLS'(pick);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            prev_q <= '0;
            deb_q  <= '0;
            ent_q  <= '0;
        end else if (tick) begin
            prev_q[row] <= ret;
            if (mode != MODE_RAW) begin
                deb_q[row] <= new_deb;
                ent_q[row] <= new_ent;
            end
        end
    end

endmodule

// File: rtl/kb_fifo.sv
module kb_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 11,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] pdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         nonempty,
    output logic         ovr
);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_q, rd_q;
    logic [CNT_W-1:0] cnt_q;
    logic             full, do_pop, do_push;

    assign full     = (cnt_q == CNT_W'(DEPTH));
    assign nonempty = (cnt_q != '0);
    assign do_pop   = pop && nonempty;
    assign do_push  = push && (!full || do_pop);
    assign rdata    = mem[rd_q];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_q] <= pdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
            ovr   <= 1'b0;
        end else begin
            if (do_push)
                wr_q <= (wr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_q + PTR_W'(1);
            if (do_pop)
                rd_q <= (rd_q == PTR_W'(DEPTH - 1)) ? '0 : rd_q + PTR_W'(1);
            if (do_push && !do_pop)
                cnt_q <= cnt_q + CNT_W'(1);
            else if (do_pop && !do_push)
                cnt_q <= cnt_q - CNT_W'(1);
            if (pop)
                ovr <= 1'b0;
            else if (push && full)
                ovr <= 1'b1;
        end
    end

endmodule

// File: rtl/kbscan_ctrl.sv
module kbscan_ctrl
    import kbscan_pkg::*;
#(
    parameter int ROWS       = KB_ROWS,
    parameter int COLS       = KB_COLS,
    parameter int FIFO_DEPTH = 8,
    parameter int PRE_W      = KB_PRE_W,
    parameter int PRESC_RST  = 3,
    localparam int ROW_W = $clog2(ROWS),
    localparam int ENT_W = ROW_W + COLS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [PRE_W+1:0] cfg_wdata,
    output logic [ROW_W-1:0] scan_row,
    input  logic [COLS-1:0]  ret_in,
    input  logic             rd_stb,
    output logic [ENT_W-1:0] rd_data,
    output logic             irq,
    output logic             ovr
);

    kb_mode_e         mode_q;
    logic [PRE_W-1:0] presc_q;
    logic             tick;
    logic             mat_push;
    logic [ROW_W-1:0] mat_row;
    logic [COLS-1:0]  mat_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= MODE_EXCL;
            presc_q <= PRE_W'(PRESC_RST);
        end else if (cfg_we) begin
            mode_q  <= kb_mode_decode(cfg_wdata[PRE_W+1:PRE_W]);
            presc_q <= cfg_wdata[PRE_W-1:0];
        end
    end

    kb_timer #(.ROWS(ROWS), .PRE_W(PRE_W)) u_tmr (
        .clk   (clk),
        .rst   (rst),
        .clear (cfg_we),
        .presc (presc_q),
        .row   (scan_row),
        .tick  (tick)
    );

    kb_matrix #(.ROWS(ROWS), .COLS(COLS)) u_mat (
        .clk       (clk),
        .rst       (rst),
        .clear     (cfg_we),
        .tick      (tick),
        .row       (scan_row),
        .ret       (ret_in),
        .mode      (mode_q),
        .push_vld  (mat_push),
        .push_row  (mat_row),
        .push_data (mat_data)
    );

    kb_fifo #(.DEPTH(FIFO_DEPTH), .W(ENT_W)) u_fifo (
        .clk      (clk),
        .rst      (rst),
        .push     (mat_push),
        .pdata    ({mat_row, mat_data}),
        .pop      (rd_stb),
        .rdata    (rd_data),
        .nonempty (irq),
        .ovr      (ovr)
    );

endmodule

// File: rtl/kbscan_ctrl_chk.sv
module kbscan_ctrl_chk #(
    parameter int ROWS  = 8,
    parameter int ROW_W = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             cfg_we,
    input logic             rd_stb,
    input logic             irq,
    input logic             ovr,
    input logic [ROW_W-1:0] scan_row,
    input logic             push_vld
);

    // R10: the queue can only become non-empty through an entry
    a_r10_irq_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(push_vld));

    // R10: the queue can only drain through a read
    a_r10_irq_fall: assert property (@(posedge clk) disable iff (rst)
        $fell(irq) |-> $past(rd_stb));

    // R11: overrun flag is sticky until a read
    a_r11_ovr_hold: assert property (@(posedge clk) disable iff (rst)
        (ovr && !rd_stb) |=> ovr);

    // R11: a read clears the overrun flag
    a_r11_ovr_clear: assert property (@(posedge clk) disable iff (rst)
        rd_stb |=> !ovr);

    // R11: overrun only happens with a full, hence non-empty, queue
    a_r11_ovr_nonempty: assert property (@(posedge clk) disable iff (rst)
        $rose(ovr) |-> irq);

    // R2: a configuration write restarts the scan at row 0
    a_r2_restart: assert property (@(posedge clk) disable iff (rst)
        cfg_we |=> (scan_row == '0));

    // R2: rows advance by one with wrap, or hold
    a_r2_row_step: assert property (@(posedge clk) disable iff (rst)
        !cfg_we |=> (scan_row == $past(scan_row)) ||
                    (($past(scan_row) == ROW_W'(ROWS - 1)) ? (scan_row == '0)
                        : (scan_row == $past(scan_row) + ROW_W'(1))));

endmodule

bind kbscan_ctrl kbscan_ctrl_chk #(.ROWS(ROWS), .ROW_W(ROW_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cfg_we   (cfg_we),
    .rd_stb   (rd_stb),
    .irq      (irq),
    .ovr      (ovr),
    .scan_row (scan_row),
    .push_vld (mat_push)
);

// File: tb/sim_kbscan_ctrl.sv
module sim_kbscan_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int SCAN = 16;   // 8 rows x 2 cycles at dwell value 1

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [9:0]  cfg_wdata = '0;
    logic [2:0]  scan_row;
    logic [7:0]  ret_in;
    logic        rd_stb = 1'b0;
    logic [10:0] rd_data;
    logic        irq;
    logic        ovr;

    logic [7:0][7:0] keymat = '0;
    int checks = 0;
    int fails = 0;

    assign ret_in = keymat[scan_row];

    always #(CLK_PERIOD / 2) clk = ~clk;

    kbscan_ctrl u0 (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .scan_row  (scan_row),
        .ret_in    (ret_in),
        .rd_stb    (rd_stb),
        .rd_data   (rd_data),
        .irq       (irq),
        .ovr       (ovr)
    );

    // {row, col} pairs for single-key entries
    localparam logic [5:0] VEC [6] = '{6'o00, 6'o07, 6'o35, 6'o52, 6'o70, 6'o77};

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_read();
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
    endtask

    task automatic set_cfg(input logic [1:0] mode, input logic [7:0] presc);
        cfg_wdata = {mode, presc};
        cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    function automatic logic [10:0] kcode(input int r, input int c);
        return {3'(r), 5'b0, 3'(c)};
    endfunction

    task automatic measure_dwell(input string req, input int exp);
        logic [2:0] r0;
        int n;
        r0 = scan_row;
        while (scan_row == r0) @(negedge clk);
        r0 = scan_row;
        n = 0;
        while (scan_row == r0 && n < 1000) begin
            @(negedge clk);
            n++;
        end
        chk(req, n, exp);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        cyc(3);
        rst = 1'b0;
        // R1: reset state
        chk("R1 irq", irq, 0);
        chk("R1 ovr", ovr, 0);
        chk("R1 scan_row", scan_row, 0);

        // R2: default dwell of 3 gives 4 cycles per row
        measure_dwell("R2 default dwell", 4);
        set_cfg(2'd0, 8'd1);
        measure_dwell("R2 dwell P=1", 2);
        while (scan_row != 3'd7) @(negedge clk);
        cyc(2);
        chk("R2 wrap to 0", scan_row, 0);

        // R4/R7: table of single keys in exclusive mode
        foreach (VEC[i]) begin
            int r = int'(VEC[i][5:3]);
            int c = int'(VEC[i][2:0]);
            keymat[r][c] = 1'b1;
            cyc(3 * SCAN);
            chk("R4 irq on key", irq, 1);
            chk("R4 key code", rd_data, kcode(r, c));
            do_read();
            chk("R9 empty after read", irq, 0);
            keymat[r][c] = 1'b0;
            cyc(3 * SCAN);
            chk("R7 release makes no entry", irq, 0);
        end

        // R3: nothing within one scan of a press
        keymat[4][3] = 1'b1;
        cyc(SCAN);
        chk("R3 no early entry", irq, 0);
        cyc(2 * SCAN);
        chk("R3 entry after settle", rd_data, kcode(4, 3));
        // R7: holding does not repeat
        cyc(4 * SCAN);
        do_read();
        chk("R7 single entry while held", irq, 0);
        keymat[4][3] = 1'b0;
        cyc(3 * SCAN);

        // R3: short glitch is rejected
        keymat[6][1] = 1'b1;
        cyc(4);
        keymat[6][1] = 1'b0;
        cyc(4 * SCAN);
        chk("R3 glitch rejected", irq, 0);

        // R9: read on empty has no effect
        do_read();
        chk("R9 empty read irq", irq, 0);
        chk("R9 empty read ovr", ovr, 0);

        // R6: exclusive mode holds back a second key
        keymat[1][2] = 1'b1;
        cyc(3 * SCAN);
        chk("R6 first key", rd_data, kcode(1, 2));
        do_read();
        keymat[5][4] = 1'b1;
        cyc(3 * SCAN);
        chk("R6 second key held back", irq, 0);
        keymat[1][2] = 1'b0;
        cyc(4 * SCAN);
        chk("R6 second key after release irq", irq, 1);
        chk("R6 second key after release", rd_data, kcode(5, 4));
        do_read();
        chk("R6 only one entry", irq, 0);
        keymat[5][4] = 1'b0;
        cyc(3 * SCAN);

        // R5: independent mode, keys in different rows
        set_cfg(2'd1, 8'd1);
        keymat[1][2] = 1'b1;
        cyc(3 * SCAN);
        keymat[5][4] = 1'b1;
        cyc(3 * SCAN);
        chk("R5 first", rd_data, kcode(1, 2));
        do_read();
        chk("R5 second", rd_data, kcode(5, 4));
        do_read();
        chk("R5 two entries only", irq, 0);
        keymat[1][2] = 1'b0;
        keymat[5][4] = 1'b0;
        cyc(3 * SCAN);

        // R5: same row, same visit: lowest column first
        keymat[3] = 8'b0100_0010;
        cyc(5 * SCAN);
        chk("R5 same row low col", rd_data, kcode(3, 1));
        do_read();
        chk("R5 same row high col", rd_data, kcode(3, 6));
        do_read();
        chk("R5 same row done", irq, 0);
        keymat[3] = 8'h00;
        cyc(3 * SCAN);

        // R11/R9: overflow with nine keys
        set_cfg(2'd1, 8'd1);
        for (int r = 0; r < 8; r++) keymat[r][0] = 1'b1;
        keymat[0][1] = 1'b1;
        cyc(6 * SCAN);
        chk("R11 ovr set", ovr, 1);
        chk("R10 irq with full queue", irq, 1);
        begin
            int n = 0;
            while (irq && n < 20) begin
                do_read();
                n++;
                if (n == 1) chk("R11 ovr cleared by read", ovr, 0);
            end
            chk("R9 depth 8", n, 8);
        end
        keymat = '0;
        cyc(3 * SCAN);

        // R8: raw mode reports pattern changes per row
        set_cfg(2'd2, 8'd1);
        cyc(2 * SCAN);
        chk("R8 no change no entry", irq, 0);
        keymat[2][5] = 1'b1;
        cyc(SCAN + 4);
        chk("R8 raw press", rd_data, {3'd2, 8'h20});
        do_read();
        chk("R8 single raw entry", irq, 0);
        keymat[2][5] = 1'b0;
        cyc(SCAN + 4);
        chk("R8 raw release", rd_data, {3'd2, 8'h00});
        do_read();
        chk("R10 irq low after drain", irq, 0);

        finish_run();
    end

endmodule